// File: doc/BRIEF.md
# Bitstream header ratio selector

This block sits beside the word stream of a 32-bit configuration bitstream and looks at the header words as they go by. Each word arrives with its position in the stream. Two header words matter. Word 69 carries the encryption setting in bits [3:2]. Word 229 carries the compression setting in bit 1, where a zero means compressed. The data itself is not forwarded; another path carries it.

When word 229 is accepted, the block combines the two settings with the configured bus width (16 or 32 bits) and selects the clock-to-data ratio. It registers the 2-bit ratio code and the width bit, and raises a one-cycle strobe. If the stream ends before word 229 has been accepted, the block raises a one-cycle error instead, and the previous ratio stays in place. A word at index 0 opens a new header. Reset also clears everything captured so far.

Top module: `hdr_ratio_sel`

## Requirements
- R1: The encryption flag is set when bits [3:2] of the valid word at index 69 are not both zero; values 01, 10 and 11 all count as encrypted.
- R2: The compression flag is the inverse of bit 1 of the valid word at index 229: bit 1 = 0 means compressed, bit 1 = 1 means not compressed.
- R3: With neither flag set, the ratio code is 2'b00 (x1) at both widths.
- R4: A compressed stream, encrypted or not, gives code 2'b10 (x4) when wide_sel = 0 (16-bit) and 2'b11 (x8) when wide_sel = 1 (32-bit).
- R5: An encrypted stream that is not compressed gives code 2'b01 (x2) at 16-bit width and 2'b10 (x4) at 32-bit width. At 32-bit width, any ratio other than x1 is the 16-bit code plus one.
- R6: The cycle after the word at index 229 is accepted, ratio_valid is high for exactly one cycle. In that same cycle ratio_code carries the new code and width_bit equals the wide_sel sampled with that word. Both outputs hold their values until the next result.
- R7: If hdr_end is seen before word 229 of the current header has been accepted, short_err is high for one cycle in the next cycle. In that case ratio_valid stays low and ratio_code is unchanged. Word 229 accepted in the same cycle as hdr_end counts as a complete header.
- R8: After reset, ratio_code, width_bit, ratio_valid and short_err are 0, and the encryption flag is clear. A header whose word 69 is missing after reset is therefore treated as not encrypted.
- R9: A valid word at index 0, or hdr_end, clears the encryption flag and the completion state, so a new header does not inherit them.
- R10: Words presented with in_valid low are ignored, whatever their index and data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Stream word valid |
| in_index | input | IDX_W | Position of the current word in the stream |
| in_data | input | DATA_W | Current stream word |
| wide_sel | input | 1 | Bus width: 1 = 32-bit, 0 = 16-bit |
| hdr_end | input | 1 | End of stream pulse |
| ratio_code | output | 2 | Ratio code: 00 x1, 01 x2, 10 x4, 11 x8 |
| width_bit | output | 1 | Registered width select for the result |
| ratio_valid | output | 1 | One-cycle strobe: a new result is on the outputs |
| short_err | output | 1 | One-cycle strobe: the header ended too early |

## Verification
Directed headers cover all four encryption field values crossed with both compression bit values and both widths. This separates a decoder that tests only one of bits [3:2] from a correct one, and an inverted compression polarity from the stated one. Further headers omit word 69, or place an invalid word carrying encryption bits at index 69, or restart with index 0 after word 69. A correct block reports x1 in these cases, while one that keeps stale flags or ignores in_valid does not. An early hdr_end must give the error strobe, no ratio strobe and an unchanged code. Seeded random headers then repeat the ratio table against a bench function that applies the plus-one rule at 32-bit width.

// File: rtl/hdr_ratio_pkg.sv
package hdr_ratio_pkg;

  typedef enum logic [1:0] {
    RATIO_X1 = 2'b00,
    RATIO_X2 = 2'b01,
    RATIO_X4 = 2'b10,
    RATIO_X8 = 2'b11
  } ratio_e;

  // 16-bit choice first, then one step up at 32-bit width unless x1.
  function automatic ratio_e ratio_of(input logic enc, input logic cmp,
                                      input logic wide);
    logic [1:0] narrow;
    if (cmp)      narrow = RATIO_X4;
    else if (enc) narrow = RATIO_X2;
    else          narrow = RATIO_X1;
    if (wide && narrow != RATIO_X1) narrow = narrow + 2'd1;
    return ratio_e'(narrow);
  endfunction

endpackage

// File: rtl/hdr_word_tap.sv
module hdr_word_tap #(
  parameter int IDX_W = 16,
  parameter int WORD  = 0
) (
  input  logic             in_valid,
  input  logic [IDX_W-1:0] in_index,
  output logic             hit
);
  localparam logic [IDX_W-1:0] WORD_IDX = IDX_W'(WORD);

  assign hit = in_valid && (in_index == WORD_IDX);
endmodule

// File: rtl/hdr_flag_track.sv
module hdr_flag_track #(
  parameter int DATA_W   = 32,
  parameter int ENC_LSB  = 2,
  parameter int ENC_BITS = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_hit,
  input  logic              enc_hit,
  input  logic              last_hit,
  input  logic              hdr_end,
  input  logic [DATA_W-1:0] in_data,
  output logic              enc_flag,
  output logic              got_last
);
  localparam int ENC_MSB = ENC_LSB + ENC_BITS - 1;

  function automatic logic enc_of(input logic [DATA_W-1:0] w);
    return |w[ENC_MSB:ENC_LSB];
  endfunction

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      enc_flag <= 1'b0;
      got_last <= 1'b0;
    end else if (hdr_end || start_hit) begin
      enc_flag <= 1'b0;
      got_last <= 1'b0;
    end else begin
      if (enc_hit)  enc_flag <= enc_of(in_data);
      if (last_hit) got_last <= 1'b1;
    end
  end
endmodule

// File: rtl/hdr_ratio_out.sv
module hdr_ratio_out (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       load,
  input  logic       err_in,
  input  logic [1:0] code_in,
  input  logic       wide_in,
  output logic [1:0] ratio_code,
  output logic       width_bit,
  output logic       ratio_valid,
  output logic       short_err
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ratio_code  <= 2'b00;
      width_bit   <= 1'b0;
      ratio_valid <= 1'b0;
      short_err   <= 1'b0;
    end else begin
      ratio_valid <= load;
      short_err   <= err_in;
      if (load) begin
        ratio_code <= code_in;
        width_bit  <= wide_in;
      end
    end
  end
endmodule

// File: rtl/hdr_ratio_sel.sv
module hdr_ratio_sel #(
  parameter int DATA_W   = 32,
  parameter int IDX_W    = 16,
  parameter int ENC_WORD = 69,
  parameter int CMP_WORD = 229,
  parameter int ENC_LSB  = 2,
  parameter int ENC_BITS = 2,
  parameter int CMP_BIT  = 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic [IDX_W-1:0]  in_index,
  input  logic [DATA_W-1:0] in_data,
  input  logic              wide_sel,
  input  logic              hdr_end,
  output logic [1:0]        ratio_code,
  output logic              width_bit,
  output logic              ratio_valid,
  output logic              short_err
);
  import hdr_ratio_pkg::*;

  localparam int TAPS = 3;
  localparam int TAP_WORD [TAPS] = '{0, ENC_WORD, CMP_WORD};

  logic [TAPS-1:0] tap_hit;
  logic start_hit, enc_hit, last_hit;
  logic enc_flag, got_last, cmp_flag, end_short;
  ratio_e code_next;
  logic unused_data;

  function automatic logic cmp_of(input logic [DATA_W-1:0] w);
    return !w[CMP_BIT];
  endfunction

  for (genvar t = 0; t < TAPS; t++) begin : g_tap
    hdr_word_tap #(.IDX_W(IDX_W), .WORD(TAP_WORD[t])) u_tap (
      .in_valid (in_valid),
      .in_index (in_index),
      .hit      (tap_hit[t])
    );
  end

  assign start_hit = tap_hit[0];
  assign enc_hit   = tap_hit[1];
  assign last_hit  = tap_hit[2];

  hdr_flag_track #(.DATA_W(DATA_W), .ENC_LSB(ENC_LSB), .ENC_BITS(ENC_BITS)) u_track (
    .clk       (clk),
    .rst_n     (rst_n),
    .start_hit (start_hit),
    .enc_hit   (enc_hit),
    .last_hit  (last_hit),
    .hdr_end   (hdr_end),
    .in_data   (in_data),
    .enc_flag  (enc_flag),
    .got_last  (got_last)
  );

  assign cmp_flag    = cmp_of(in_data);
  assign code_next   = ratio_of(enc_flag, cmp_flag, wide_sel);
  assign end_short   = hdr_end && !(got_last || last_hit);
  assign unused_data = ^in_data;

  hdr_ratio_out u_out (
    .clk         (clk),
    .rst_n       (rst_n),
    .load        (last_hit),
    .err_in      (end_short),
    .code_in     (code_next),
    .wide_in     (wide_sel),
    .ratio_code  (ratio_code),
    .width_bit   (width_bit),
    .ratio_valid (ratio_valid),
    .short_err   (short_err)
  );
endmodule

// File: rtl/hdr_ratio_chk.sv
module hdr_ratio_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       last_hit,
  input logic       start_hit,
  input logic       hdr_end,
  input logic       enc_flag,
  input logic       ratio_valid,
  input logic       short_err,
  input logic [1:0] ratio_code,
  input logic       width_bit
);
  AST_VALID_AFTER_LAST: assert property (@(posedge clk) disable iff (!rst_n)
    ratio_valid |-> $past(last_hit)); // R6
  AST_LAST_GIVES_VALID: assert property (@(posedge clk) disable iff (!rst_n)
    last_hit |=> ratio_valid); // R6
  AST_CODE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !ratio_valid |-> $stable(ratio_code) && $stable(width_bit)); // R7
  AST_ERR_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
    !(ratio_valid && short_err)); // R7
  AST_ERR_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    short_err |-> $past(hdr_end)); // R7
  AST_WIDE_NO_X2: assert property (@(posedge clk) disable iff (!rst_n)
    ratio_valid && width_bit |-> ratio_code != 2'b01); // R5
  AST_NARROW_NO_X8: assert property (@(posedge clk) disable iff (!rst_n)
    ratio_valid && !width_bit |-> ratio_code != 2'b11); // R4
  AST_START_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    start_hit |=> !enc_flag); // R9
endmodule

bind hdr_ratio_sel hdr_ratio_chk u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .last_hit    (last_hit),
  .start_hit   (start_hit),
  .hdr_end     (hdr_end),
  .enc_flag    (enc_flag),
  .ratio_valid (ratio_valid),
  .short_err   (short_err),
  .ratio_code  (ratio_code),
  .width_bit   (width_bit)
);

// File: tb/tb_hdr_ratio_sel.sv
`timescale 1ns/1ps
module tb_hdr_ratio_sel;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic [15:0] in_index = '0;
  logic [31:0] in_data = '0;
  logic        wide_sel = 1'b0;
  logic        hdr_end = 1'b0;
  logic [1:0]  ratio_code;
  logic        width_bit, ratio_valid, short_err;

  int checks = 0;
  int errors = 0;
  bit done = 0;
  logic [1:0] last_code = 2'b00;
  logic       last_wide = 1'b0;

  always #10 clk = ~clk;

  hdr_ratio_sel dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_index(in_index),
    .in_data(in_data), .wide_sel(wide_sel), .hdr_end(hdr_end),
    .ratio_code(ratio_code), .width_bit(width_bit),
    .ratio_valid(ratio_valid), .short_err(short_err)
  );

  function automatic logic [1:0] exp_code(logic [31:0] w69, logic [31:0] w229,
                                          bit wide, bit has69);
    bit enc = has69 && (w69[3] || w69[2]);
    bit cmp = (w229[1] == 1'b0);
    int steps;
    if (!enc && !cmp) return 2'b00;
    steps = cmp ? 2 : 1;       // x4 or x2 at 16-bit width
    if (wide) steps = steps + 1;
    return 2'(steps);
  endfunction

  function automatic string tag_of(logic [31:0] w69, logic [31:0] w229, bit has69);
    if (w229[1] == 1'b0) return "R4";
    if (has69 && (w69[3:2] != 2'b00)) return "R5";
    return "R3";
  endfunction

  task automatic chk(bit ok, string tag, int act, int expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, expv);
    end
  endtask

  task automatic put(bit v, int idx, logic [31:0] d);
    @(negedge clk);
    in_valid = v;
    in_index = 16'(idx);
    in_data  = d;
  endtask

  task automatic close_hdr(bit expect_err, string tag);
    @(negedge clk);
    in_valid = 1'b0;
    hdr_end  = 1'b1;
    @(negedge clk);
    hdr_end  = 1'b0;
    chk(short_err == expect_err, tag, short_err, expect_err);
    chk(ratio_valid == 1'b0, tag, ratio_valid, 0);
    chk(ratio_code == last_code, tag, ratio_code, last_code);
  endtask

  task automatic stream(logic [31:0] w69, logic [31:0] w229, bit wide,
                        bit has69, bit restart, string tag);
    logic [1:0] e = restart ? exp_code(w69, w229, wide, 1'b0)
                            : exp_code(w69, w229, wide, has69);
    put(1'b1, 0, $urandom);
    put(1'b1, 17, $urandom);
    if (has69) put(1'b1, 69, w69);
    else put(1'b0, 69, 32'hFFFF_FFFF);
    if (restart) put(1'b1, 0, 32'h0000_000C);
    put(1'b1, 100, 32'h0000_0000);
    put(1'b1, 229, w229);
    wide_sel = wide;
    @(negedge clk);
    in_valid = 1'b0;
    wide_sel = ~wide;
    chk(ratio_valid == 1'b1, "R6", ratio_valid, 1);
    chk(ratio_code == e, tag, ratio_code, e);
    chk(width_bit == wide, "R6", width_bit, wide);
    last_code = e;
    last_wide = wide;
    @(negedge clk);
    chk(ratio_valid == 1'b0, "R6", ratio_valid, 0);
    chk(ratio_code == e, "R6", ratio_code, e);
    close_hdr(1'b0, "R7");
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1;
      errors++;
      checks++;
      $display("FAIL watchdog actual=0 expected=1");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4321));
    repeat (3) @(negedge clk);
    chk(ratio_code == 2'b00, "R8", ratio_code, 0);
    chk(width_bit == 1'b0, "R8", width_bit, 0);
    chk(ratio_valid == 1'b0, "R8", ratio_valid, 0);
    chk(short_err == 1'b0, "R8", short_err, 0);
    rst_n = 1'b1;
    // R8 and R10: word 69 not valid, its encryption bits must be ignored
    stream(32'hFFFF_FFFF, 32'h0000_0002, 1'b1, 1'b0, 1'b0, "R10");
    // R1, R2 directed table: every encryption field value, both polarities, both widths
    for (int f = 0; f < 4; f++)
      for (int c = 0; c < 2; c++)
        for (int w = 0; w < 2; w++) begin
          logic [31:0] a = 32'(f) << 2;
          logic [31:0] b = 32'(c) << 1;
          string t = (f != 0 && c == 1) ? "R1" : (c == 0 ? "R2" : tag_of(a, b, 1'b1));
          stream(a | 32'hFFFF_FFF3, b | 32'hFFFF_FFFD, w[0], 1'b1, 1'b0, t);
        end
    // R9: restart after an encrypted word 69 forgets the flag
    stream(32'h0000_000C, 32'h0000_0002, 1'b0, 1'b1, 1'b1, "R9");
    // R7: end before word 229 gives error only
    stream(32'h0000_0004, 32'h0000_0002, 1'b1, 1'b1, 1'b0, "R5");
    put(1'b1, 0, 32'h0);
    put(1'b1, 69, 32'h0000_000C);
    put(1'b1, 228, 32'h0);
    close_hdr(1'b1, "R7");
    // R7: word 229 together with hdr_end is complete
    put(1'b1, 0, 32'h0);
    @(negedge clk);
    in_valid = 1'b1; in_index = 16'd229; in_data = 32'h0; wide_sel = 1'b0; hdr_end = 1'b1;
    @(negedge clk);
    in_valid = 1'b0; hdr_end = 1'b0;
    chk(short_err == 1'b0, "R7", short_err, 0);
    chk(ratio_valid == 1'b1, "R7", ratio_valid, 1);
    chk(ratio_code == 2'b10, "R4", ratio_code, 2);
    last_code = 2'b10;
    // random headers
    for (int n = 0; n < 60; n++) begin
      logic [31:0] a = $urandom;
      logic [31:0] b = $urandom;
      bit w = 1'($urandom);
      stream(a, b, w, 1'b1, 1'b0, tag_of(a, b, 1'b1));
    end
    if (!done) begin
      done = 1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule